// File: doc/BRIEF.md
# Reference Selection and Holdover Controller

This block decides which of two reference clocks, called A and B, drives the input of a phase-locked loop. Each reference comes with a valid flag from an upstream loss-of-reference monitor. The block does not trust a flag as soon as it rises. A reference becomes usable only after its flag has stayed high for a programmable number of consecutive clock edges. A usable reference stops being usable as soon as its flag drops.

The block has two selection modes. In manual mode, an external select pin names the reference and the block follows it. In automatic mode, the block moves from a failed reference to the other one. When A recovers while B is in use, a revert-enable bit decides whether the block goes back to A or stays on B. If neither reference is usable, the block enters holdover. It can then ask for the oscillator control voltage to be parked at midscale. Each change of the selected reference is flagged with a one-cycle pulse.

Top module: `ref_holdover_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, refSel is 0, holdover is 1 and switchPulse is 0.
- R2: A reference is usable only on an edge where its valid input has been sampled high on that edge and on the QUAL_CYCLES edges before it. A single low sample restarts the count. Loss of usability takes effect on the first edge where valid is sampled low.
- R3: With selMode = 1 (manual), refSel takes the value of manualSel sampled on the previous edge, whatever the valid inputs are.
- R4: With selMode = 0 (automatic) and no holdover, if the selected reference is not usable and the other one is, refSel moves to the other one on that edge. If the selected reference is usable, refSel stays unless R5 applies.
- R5: In automatic mode with refSel = 1 (B) and B usable, a usable A moves refSel to 0 only when revertEn = 1. With revertEn = 0, refSel stays at 1.
- R6: On any edge where neither reference is usable, holdover becomes 1 in either mode. In automatic mode, refSel keeps its value while holdover is set.
- R7: In automatic mode, holdover clears on the first edge where a reference is usable. refSel becomes 0 if A is usable, and 1 otherwise.
- R8: statusB equals refSel (1 = B, 0 = A) when selMode = 0, and is 0 when selMode = 1.
- R9: parkReq is 1 exactly when parkEn is 1 and holdover is 1.
- R10: refSel changes only at a clock edge. switchPulse is 1 for exactly the cycle that follows each change of refSel, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| validA | input | 1 | Monitor flag for reference A |
| validB | input | 1 | Monitor flag for reference B |
| selMode | input | 1 | 0 = automatic selection, 1 = manual by pin |
| manualSel | input | 1 | Manual choice, 0 = A, 1 = B |
| revertEn | input | 1 | Return to A once it is usable again (automatic mode) |
| parkEn | input | 1 | Allow the midscale park request during holdover |
| refSel | output | 1 | Selected reference, 0 = A, 1 = B |
| holdover | output | 1 | No usable reference |
| statusB | output | 1 | Selected-reference status for automatic mode |
| parkReq | output | 1 | Request to hold the oscillator control voltage at midscale |
| switchPulse | output | 1 | One-cycle pulse after each change of refSel |

## Verification
The assertions check four rules on every cycle. An edge with both flags low must be followed by holdover. The switch pulse must match a change of the selection. In manual mode the selection must follow the pin. The status and park outputs must never be set outside their allowed conditions. Other behaviour depends on how the usability counters reached their state: qualification timing, the choice between staying and reverting, and the choice made on leaving holdover. Only the bench scenarios can show these. The bench runs every combination of mode, revert and park settings against toggling valid patterns. It also runs a directed case in which a flag drops one edge short of qualifying.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

  localparam int NUM_REFS = 2;
  localparam int REF_A = 0;
  localparam int REF_B = 1;

  typedef enum logic {
    SEL_AUTO   = 1'b0,
    SEL_MANUAL = 1'b1
  } selMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // update the selection register this edge
    logic sel;    // value to load, 0 = A, 1 = B
  } ctrlStrobe_t;

endpackage

// File: rtl/refsel_datapath.sv
module refsel_datapath
  import refsel_pkg::*;
#(
  parameter int QUAL_CYCLES = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_REFS-1:0] validIn,
  input  ctrlStrobe_t         strobe,
  output logic [NUM_REFS-1:0] qualOut,
  output logic                refSel,
  output logic                switchPulse
);

  localparam int CNT_W = $clog2(QUAL_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(QUAL_CYCLES);

  // one run-length qualifier per reference
  for (genvar g = 0; g < NUM_REFS; g++) begin : g_qual
    logic [CNT_W-1:0] runCnt;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        runCnt <= '0;
      end else if (!validIn[g]) begin
        runCnt <= '0;
      end else if (runCnt != CNT_MAX) begin
        runCnt <= runCnt + 1'b1;
      end
    end

    assign qualOut[g] = validIn[g] && (runCnt == CNT_MAX);
  end

  // selection register and change pulse
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refSel      <= 1'b0;
      switchPulse <= 1'b0;
    end else begin
      switchPulse <= strobe.load && (strobe.sel != refSel);
      if (strobe.load) begin
        refSel <= strobe.sel;
      end
    end
  end

endmodule

// File: rtl/refsel_control.sv
module refsel_control
  import refsel_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_REFS-1:0] qualIn,
  input  logic                curSel,
  input  selMode_e            mode,
  input  logic                manualSel,
  input  logic                revertEn,
  output ctrlStrobe_t         strobe,
  output logic                holdover
);

  logic holdReg;
  logic holdNext;
  logic okA;
  logic okB;
  logic noneOk;

  assign okA    = qualIn[REF_A];
  assign okB    = qualIn[REF_B];
  assign noneOk = !okA && !okB;

  always_comb begin
    strobe   = '0;
    holdNext = holdReg;
    if (mode == SEL_MANUAL) begin
      strobe.load = 1'b1;
      strobe.sel  = manualSel;
      holdNext    = noneOk;
    end else if (holdReg) begin
      // leaving holdover prefers A
      if (okA) begin
        strobe.load = 1'b1;
        strobe.sel  = 1'b0;
        holdNext    = 1'b0;
      end else if (okB) begin
        strobe.load = 1'b1;
        strobe.sel  = 1'b1;
        holdNext    = 1'b0;
      end
    end else if (!curSel) begin
      if (!okA) begin
        if (okB) begin
          strobe.load = 1'b1;
          strobe.sel  = 1'b1;
        end else begin
          holdNext = 1'b1;
        end
      end
    end else begin
      if (!okB) begin
        if (okA) begin
          strobe.load = 1'b1;
          strobe.sel  = 1'b0;
        end else begin
          holdNext = 1'b1;
        end
      end else if (okA && revertEn) begin
        strobe.load = 1'b1;
        strobe.sel  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg <= 1'b1;
    end else begin
      holdReg <= holdNext;
    end
  end

  assign holdover = holdReg;

endmodule

// File: rtl/ref_holdover_ctrl.sv
module ref_holdover_ctrl
  import refsel_pkg::*;
#(
  parameter int QUAL_CYCLES = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic validA,
  input  logic validB,
  input  logic selMode,
  input  logic manualSel,
  input  logic revertEn,
  input  logic parkEn,
  output logic refSel,
  output logic holdover,
  output logic statusB,
  output logic parkReq,
  output logic switchPulse
);

  logic [NUM_REFS-1:0] qualVec;
  ctrlStrobe_t         strobe;
  selMode_e            modeE;

  assign modeE = selMode_e'(selMode);

  refsel_datapath #(.QUAL_CYCLES(QUAL_CYCLES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .validIn    ({validB, validA}),
    .strobe     (strobe),
    .qualOut    (qualVec),
    .refSel     (refSel),
    .switchPulse(switchPulse)
  );

  refsel_control u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .qualIn   (qualVec),
    .curSel   (refSel),
    .mode     (modeE),
    .manualSel(manualSel),
    .revertEn (revertEn),
    .strobe   (strobe),
    .holdover (holdover)
  );

  assign statusB = (modeE == SEL_AUTO) ? refSel : 1'b0;
  assign parkReq = parkEn && holdover;

endmodule

// File: rtl/ref_holdover_ctrl_chk.sv
module ref_holdover_ctrl_chk (
  input logic clk,
  input logic rstN,
  input logic validA,
  input logic validB,
  input logic selMode,
  input logic manualSel,
  input logic parkEn,
  input logic refSel,
  input logic holdover,
  input logic statusB,
  input logic parkReq,
  input logic switchPulse
);

  p_hold_on_loss_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!validA && !validB) |=> holdover);

  p_pulse_on_change_r10: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (switchPulse == (refSel != $past(refSel))));

  p_follow_pin_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && selMode && $past(selMode)) |-> (refSel == $past(manualSel)));

  p_park_gated_r9: assert property (@(posedge clk) disable iff (!rstN)
    parkReq |-> (holdover && parkEn));

  p_status_manual_r8: assert property (@(posedge clk) disable iff (!rstN)
    selMode |-> !statusB);

endmodule

bind ref_holdover_ctrl ref_holdover_ctrl_chk u_chk (.*);

// File: tb/sim_ref_holdover_ctrl.sv
`timescale 1ns/1ps
module sim_ref_holdover_ctrl;

  localparam int Q = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic validA = 1'b0, validB = 1'b0, selMode = 1'b0, manualSel = 1'b0;
  logic revertEn = 1'b0, parkEn = 1'b0;
  logic refSel, holdover, statusB, parkReq, switchPulse;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ref_holdover_ctrl #(.QUAL_CYCLES(Q)) u0 (
    .clk(clk), .rstN(rstN), .validA(validA), .validB(validB),
    .selMode(selMode), .manualSel(manualSel), .revertEn(revertEn),
    .parkEn(parkEn), .refSel(refSel), .holdover(holdover),
    .statusB(statusB), .parkReq(parkReq), .switchPulse(switchPulse)
  );

  // requirement-level model
  int    cntA = 0, cntB = 0;
  logic  mSel = 1'b0, mHold = 1'b1, mPulse = 1'b0;
  string mTag = "R1";

  always @(posedge clk) begin
    logic qa, qb, nSel, nHold;
    if (!rstN) begin
      cntA = 0; cntB = 0; mSel = 1'b0; mHold = 1'b1; mPulse = 1'b0; mTag = "R1";
    end else begin
      qa = validA && (cntA >= Q);
      qb = validB && (cntB >= Q);
      nSel = mSel; nHold = mHold; mTag = "R4";
      if (selMode) begin
        nSel = manualSel; nHold = !qa && !qb; mTag = "R3";
      end else if (mHold) begin
        if (qa) begin nSel = 1'b0; nHold = 1'b0; mTag = "R7"; end
        else if (qb) begin nSel = 1'b1; nHold = 1'b0; mTag = "R7"; end
      end else if (!mSel) begin
        if (!qa) begin if (qb) nSel = 1'b1; else nHold = 1'b1; end
      end else begin
        if (!qb) begin if (qa) nSel = 1'b0; else nHold = 1'b1; end
        else begin mTag = "R5"; if (qa && revertEn) nSel = 1'b0; end
      end
      mPulse = (nSel != mSel);
      mSel = nSel; mHold = nHold;
      cntA = validA ? ((cntA >= Q) ? Q : cntA + 1) : 0;
      cntB = validB ? ((cntB >= Q) ? Q : cntB + 1) : 0;
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compareAll(input string holdTag);
    chk(refSel, mSel, mTag, "refSel");
    chk(holdover, mHold, holdTag, "holdover");
    chk(statusB, selMode ? 1'b0 : mSel, "R8", "statusB");
    chk(parkReq, parkEn && mHold, "R9", "parkReq");
    chk(switchPulse, mPulse, "R10", "switchPulse");
  endtask

  logic [15:0] lfsr = 16'hACE1;
  task automatic stepLfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(refSel, 1'b0, "R1", "refSel in reset");
    chk(holdover, 1'b1, "R1", "holdover in reset");
    chk(switchPulse, 1'b0, "R1", "switchPulse in reset");
    rstN = 1'b1;
    @(negedge clk);
    compareAll("R1");

    // R2: A high one edge short of qualifying, then dropped
    validA = 1'b1;
    for (int i = 0; i < Q; i++) begin @(negedge clk); compareAll("R2"); end
    chk(holdover, 1'b1, "R2", "still holdover before qualification");
    validA = 1'b0;
    @(negedge clk); compareAll("R2");
    validA = 1'b1;
    for (int i = 0; i < Q; i++) begin @(negedge clk); compareAll("R2"); end
    chk(holdover, 1'b1, "R2", "holdover after count restart");
    @(negedge clk); compareAll("R2");
    chk(holdover, 1'b0, "R2", "holdover cleared on qualifying edge");

    // sweep all mode/revert/park combinations
    for (int cfg = 0; cfg < 8; cfg++) begin
      selMode = cfg[0]; revertEn = cfg[1]; parkEn = cfg[2];
      for (int c = 0; c < 500; c++) begin
        @(negedge clk);
        compareAll("R6");
        stepLfsr();
        if (lfsr[3:0] == 4'h0) validA = ~validA;
        if (lfsr[7:4] == 4'h5) validB = ~validB;
        if (lfsr[11:8] == 4'h3) manualSel = ~manualSel;
      end
    end

    // mixed phase with mode and revert changing on the fly
    for (int c = 0; c < 2000; c++) begin
      @(negedge clk);
      compareAll("R6");
      stepLfsr();
      if (lfsr[3:0] == 4'h0) validA = ~validA;
      if (lfsr[7:4] == 4'h5) validB = ~validB;
      if (lfsr[11:8] == 4'h3) manualSel = ~manualSel;
      if (lfsr[15:10] == 6'h11) selMode = ~selMode;
      if (lfsr[15:11] == 5'h07) revertEn = ~revertEn;
      if (lfsr[14:10] == 5'h0c) parkEn = ~parkEn;
    end

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule